// File: doc/BRIEF.md
# Descriptor Retirement and Completion Tracker

This block sits beside a descriptor-ring DMA engine and keeps track of which packet requests are still in flight. Software-side logic hands it each request as it is posted to the ring: the ring index one past the request's last descriptor, the number of descriptors the request consumed, and a tag. The engine reports its hardware head pointer. Whenever that pointer moves ahead of the tracker's own head, the tracker walks its head forward one ring slot per clock and counts every slot it passes as a retired descriptor.

Requests are held in a small in-order queue. When the walking head lands on the end index of the oldest queued request, that request is reported complete with a success status and leaves the queue. Slots that do not finish the oldest request, such as header descriptors or slots with no request, are retired silently. An abort, requested explicitly or caused by posting a request while the engine is stopped, drains the whole queue in posting order with an aborted status. It then resynchronises the retired count to the posted count and returns the head to slot 0. A progress pulse after each step tells the producer that the free-slot figure has changed.

Top module: `desc_retire_tracker`

## Requirements
- R1: After reset, `sw_head` is 0, `retired_cnt` is 0, `free_cnt` is RING_SIZE-1, and `cmpl_valid`, `progress` and `q_full` are 0.
- R2: While `sw_head` differs from `hw_head` and no abort is in progress, `sw_head` advances by exactly one slot per clock, going from RING_SIZE-1 to 0, and it stops when it equals `hw_head`.
- R3: `retired_cnt` increases by one for every slot `sw_head` advances and never decreases.
- R4: When `sw_head` advances onto the end index of the oldest queued request, that request completes in the same clock with `cmpl_valid`=1, its tag on `cmpl_tag` and `cmpl_aborted`=0 (success status). The request after it in the queue becomes the oldest.
- R5: A step that does not land on the oldest request's end index retires a slot but raises no completion.
- R6: When `flush` is asserted, every queued request completes in posting order with `cmpl_aborted`=1 (aborted status), one per consecutive clock, and no slot is retired meanwhile.
- R7: Once an abort has drained the queue, `sw_head` is 0, `retired_cnt` equals the total `enq_ndesc` of all requests accepted while running, `free_cnt` is RING_SIZE-1 and `q_full` is 0.
- R8: A request posted while `running` is 0 is queued behind any earlier requests and starts an abort, so it and all earlier requests complete aborted in posting order.
- R9: `progress` is 1 in exactly the cycles after a step, and `free_cnt` always equals RING_SIZE-1 minus (accepted descriptors minus retired descriptors).
- R10: `q_full` is 1 while QDEPTH requests are queued. A request posted while `q_full` is 1 is dropped: it never completes and does not change `free_cnt`.
- R11: At most one completion is reported per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| running | input | 1 | Engine is running; posting while low aborts |
| hw_head | input | IDX_W | Hardware head pointer of the ring |
| enq_valid | input | 1 | Post a request this cycle |
| enq_end | input | IDX_W | Ring index one past the request's last descriptor |
| enq_ndesc | input | IDX_W | Descriptors consumed by the request |
| enq_tag | input | TAG_W | Request tag returned on completion |
| flush | input | 1 | Abort all queued requests |
| q_full | output | 1 | Request queue holds QDEPTH entries |
| cmpl_valid | output | 1 | A completion is reported this cycle |
| cmpl_tag | output | TAG_W | Tag of the completed request |
| cmpl_aborted | output | 1 | 1 = aborted status, 0 = success |
| progress | output | 1 | At least one slot retired in the last update |
| sw_head | output | IDX_W | Tracker head index |
| retired_cnt | output | CNT_W | Running count of retired descriptors |
| free_cnt | output | IDX_W+1 | Free ring slots |

## Verification
A corrupted head register shows up within one step as a completion whose reported head differs from the request's end index, or as a missing completion after the head catches up. A wrong retired count appears at once in `free_cnt`, and again when the idle ring does not report RING_SIZE-1 free slots. Queue-order or status faults show as tags arriving out of posting order, or with the wrong status bit, within a few cycles of the head reaching the end index or of an abort. Sweeping every request length across several ring wraps exercises every wrap position of the head.

// File: rtl/drt_pkg.sv
// Shared types and helpers for the descriptor retirement tracker.
// Assumes ring indices fit in 32 bits.
package drt_pkg;

    typedef enum logic {
        ST_OK    = 1'b0,
        ST_ABORT = 1'b1
    } cmpl_status_e;

    // Next ring index, wrapping to 0 at the ring size.
    function automatic int unsigned ring_inc(input int unsigned idx, input int unsigned size);
        return (idx + 1 == size) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/drt_req_fifo.sv
// In-order request queue. A push when full is dropped; a pop when empty is
// ignored. Push and pop in the same cycle are both honoured.
// Assumes DEPTH >= 1.
module drt_req_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Entry storage, written on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/drt_ring_head.sv
// Software head walker: steps the head one slot per enabled cycle with
// wrap at RING_SIZE, counting each step as a retired descriptor. A clear
// returns the head to 0 and loads the retired count with a given value.
module drt_ring_head #(
    parameter int RING_SIZE = 64,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic [CNT_W-1:0] clear_cnt,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] next_head,
    output logic [CNT_W-1:0] retired
);
    // Index the head moves to on a step.
    assign next_head = IDX_W'(drt_pkg::ring_inc(32'(head), RING_SIZE));

    // Head and retired-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head    <= '0;
            retired <= '0;
        end else if (clear) begin
            head    <= '0;
            retired <= clear_cnt;
        end else if (step) begin
            head    <= next_head;
            retired <= retired + 1'b1;
        end
    end
endmodule

// File: rtl/desc_retire_tracker.sv
// Descriptor retirement and completion tracker (top).
// Walks a software head toward the hardware head, retires one slot per
// cycle, completes the oldest request when the head lands on its end
// index, and drains the queue as aborted on flush or on a post while the
// engine is stopped. Assumes in-flight descriptors never exceed
// RING_SIZE-1 and that the hardware head is returned to 0 with a flush.
module desc_retire_tracker #(
    parameter int RING_SIZE = 64,
    parameter int QDEPTH    = 8,
    parameter int TAG_W     = 8,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running,
    input  logic [IDX_W-1:0] hw_head,
    input  logic             enq_valid,
    input  logic [IDX_W-1:0] enq_end,
    input  logic [IDX_W-1:0] enq_ndesc,
    input  logic [TAG_W-1:0] enq_tag,
    input  logic             flush,
    output logic             q_full,
    output logic             cmpl_valid,
    output logic [TAG_W-1:0] cmpl_tag,
    output logic             cmpl_aborted,
    output logic             progress,
    output logic [IDX_W-1:0] sw_head,
    output logic [CNT_W-1:0] retired_cnt,
    output logic [IDX_W:0]   free_cnt
);
    import drt_pkg::*;

    localparam int ENT_W = TAG_W + IDX_W;

    logic             flush_busy;
    logic             start_flush, push_acc, clear, step, hit, pop, q_empty;
    logic [ENT_W-1:0] front;
    logic [IDX_W-1:0] front_end, next_head;
    logic [TAG_W-1:0] front_tag;
    logic [CNT_W-1:0] added;
    cmpl_status_e     cmpl_st;

    assign {front_tag, front_end} = front;

    assign start_flush = flush || (enq_valid && !running);
    assign push_acc    = enq_valid && !q_full;
    assign clear       = flush_busy && q_empty && !push_acc;
    assign step        = !flush_busy && !start_flush && (sw_head != hw_head);
    assign hit         = !q_empty && (front_end == next_head);
    assign pop         = flush_busy ? !q_empty : (step && hit);

    drt_req_fifo #(.DEPTH(QDEPTH), .WIDTH(ENT_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (enq_valid),
        .din   ({enq_tag, enq_end}),
        .pop   (pop),
        .dout  (front),
        .empty (q_empty),
        .full  (q_full)
    );

    drt_ring_head #(.RING_SIZE(RING_SIZE), .CNT_W(CNT_W)) u_head (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .clear     (clear),
        .clear_cnt (added),
        .head      (sw_head),
        .next_head (next_head),
        .retired   (retired_cnt)
    );

    // Abort sequencing: set by a flush request, held until the queue drains.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_busy <= 1'b0;
        else        flush_busy <= start_flush || (flush_busy && !clear);
    end

    // Posted-descriptor count, advanced only for requests accepted while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            added <= '0;
        else if (push_acc && running && !flush_busy)
            added <= added + CNT_W'(enq_ndesc);
    end

    // Completion and progress outputs, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpl_valid <= 1'b0;
            cmpl_tag   <= '0;
            cmpl_st    <= ST_OK;
            progress   <= 1'b0;
        end else begin
            cmpl_valid <= pop;
            cmpl_tag   <= front_tag;
            cmpl_st    <= flush_busy ? ST_ABORT : ST_OK;
            progress   <= step;
        end
    end

    assign cmpl_aborted = (cmpl_st == ST_ABORT);
    assign free_cnt     = (IDX_W + 1)'(RING_SIZE - 1) - (IDX_W + 1)'(added - retired_cnt);
endmodule

// File: rtl/drt_checker.sv
// Property checker for the descriptor retirement tracker, bound to the top.
module drt_checker #(
    parameter int RING_SIZE = 64,
    parameter int CNT_W     = 16,
    localparam int IDX_W    = (RING_SIZE > 1) ? $clog2(RING_SIZE) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmpl_valid,
    input logic             cmpl_aborted,
    input logic             progress,
    input logic [IDX_W-1:0] sw_head,
    input logic [CNT_W-1:0] retired_cnt
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(RING_SIZE - 1);

    // R2
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        progress |-> sw_head == (($past(sw_head) == LAST) ? '0 : $past(sw_head) + 1'b1));

    // R3
    retired_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retired_cnt >= $past(retired_cnt));

    // R9
    progress_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        progress |-> retired_cnt == $past(retired_cnt) + 1'b1);

    // R4
    ok_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && !cmpl_aborted) |-> progress);

    // R6
    abort_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_aborted) |-> !progress);
endmodule

bind desc_retire_tracker drt_checker #(.RING_SIZE(RING_SIZE), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmpl_valid   (cmpl_valid),
    .cmpl_aborted (cmpl_aborted),
    .progress     (progress),
    .sw_head      (sw_head),
    .retired_cnt  (retired_cnt)
);

// File: tb/desc_retire_tracker_tb.sv
`timescale 1ns/1ps
module desc_retire_tracker_tb;
    localparam int RING = 8;
    localparam int QD   = 4;
    localparam int TW   = 4;
    localparam int CW   = 16;
    localparam int IW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          running = 1'b0;
    logic [IW-1:0] hw_head = '0;
    logic          enq_valid = 1'b0;
    logic [IW-1:0] enq_end = '0;
    logic [IW-1:0] enq_ndesc = '0;
    logic [TW-1:0] enq_tag = '0;
    logic          flush = 1'b0;
    logic          q_full, cmpl_valid, cmpl_aborted, progress;
    logic [TW-1:0] cmpl_tag;
    logic [IW-1:0] sw_head;
    logic [CW-1:0] retired_cnt;
    logic [IW:0]   free_cnt;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int ncmpl = 0;
    int npro = 0;
    int log_tag [256];
    int log_ab  [256];
    int log_hd  [256];
    int log_cyc [256];

    always #2.5 clk = ~clk;

    desc_retire_tracker #(.RING_SIZE(RING), .QDEPTH(QD), .TAG_W(TW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .running(running), .hw_head(hw_head),
        .enq_valid(enq_valid), .enq_end(enq_end), .enq_ndesc(enq_ndesc),
        .enq_tag(enq_tag), .flush(flush), .q_full(q_full),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag), .cmpl_aborted(cmpl_aborted),
        .progress(progress), .sw_head(sw_head), .retired_cnt(retired_cnt),
        .free_cnt(free_cnt)
    );

    // Completion and progress logger, sampling just after each edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n && cmpl_valid && ncmpl < 256) begin
            log_tag[ncmpl] = int'(cmpl_tag);
            log_ab[ncmpl]  = int'(cmpl_aborted);
            log_hd[ncmpl]  = int'(sw_head);
            log_cyc[ncmpl] = cyc;
            ncmpl++;
        end
        if (rst_n && progress) npro++;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic post(input int e, input int n, input int t);
        @(negedge clk);
        enq_valid = 1'b1;
        enq_end   = IW'(e);
        enq_ndesc = IW'(n);
        enq_tag   = TW'(t);
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int h;
        int added;
        int base;
        int pbase;
        h = 0;
        added = 0;

        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1", "sw_head", int'(sw_head), 0);
        chk("R1", "retired_cnt", int'(retired_cnt), 0);
        chk("R1", "free_cnt", int'(free_cnt), RING - 1);
        chk("R1", "cmpl_valid", int'(cmpl_valid), 0);
        chk("R1", "progress", int'(progress), 0);
        chk("R1", "q_full", int'(q_full), 0);

        running = 1'b1;
        // R2 R3 R4 R9: every request length over three ring wraps
        for (int r = 0; r < 3; r++) begin
            for (int len = 1; len < RING; len++) begin
                int e;
                int t;
                e = (h + len) % RING;
                t = (len + r * 7) % 16;
                base = ncmpl;
                pbase = npro;
                post(e, len, t);
                chk("R9", "free_cnt after post", int'(free_cnt), RING - 1 - len);
                hw_head = IW'(e);
                idle(len + 3);
                added += len;
                chk("R4", "completion count", ncmpl - base, 1);
                chk("R4", "completion tag", log_tag[base], t);
                chk("R4", "completion status ok", log_ab[base], 0);
                chk("R4", "head at completion", log_hd[base], e);
                chk("R2", "sw_head caught up", int'(sw_head), e);
                chk("R3", "retired_cnt", int'(retired_cnt), added);
                chk("R9", "progress pulses", npro - pbase, len);
                chk("R9", "free_cnt idle", int'(free_cnt), RING - 1);
                h = e;
            end
        end

        // R5: slots short of the end index retire without a completion
        base = ncmpl;
        post((h + 5) % RING, 5, 9);
        hw_head = IW'((h + 3) % RING);
        idle(6);
        chk("R5", "no completion on partial walk", ncmpl - base, 0);
        chk("R5", "retired on partial walk", int'(retired_cnt), added + 3);
        chk("R2", "sw_head partial", int'(sw_head), (h + 3) % RING);
        hw_head = IW'((h + 5) % RING);
        idle(5);
        added += 5;
        chk("R5", "completion at end index", ncmpl - base, 1);
        chk("R5", "head at completion", log_hd[base], (h + 5) % RING);
        h = (h + 5) % RING;

        // R4: two requests complete in posting order two cycles apart
        base = ncmpl;
        post((h + 2) % RING, 2, 3);
        post((h + 4) % RING, 2, 4);
        hw_head = IW'((h + 4) % RING);
        idle(7);
        added += 4;
        chk("R4", "two completions", ncmpl - base, 2);
        chk("R4", "first tag", log_tag[base], 3);
        chk("R4", "second tag", log_tag[base + 1], 4);
        chk("R4", "cycle gap", log_cyc[base + 1] - log_cyc[base], 2);
        h = (h + 4) % RING;

        // R10 R6 R7: fill the queue, drop an extra post, then abort
        base = ncmpl;
        for (int i = 0; i < QD; i++) post((h + 1 + i) % RING, 1, 10 + i);
        added += QD;
        chk("R10", "q_full at depth", int'(q_full), 1);
        post((h + 5) % RING, 1, 14);
        chk("R10", "free_cnt unchanged by dropped post", int'(free_cnt), RING - 1 - QD);
        chk("R10", "no completion yet", ncmpl - base, 0);
        @(negedge clk);
        flush = 1'b1;
        hw_head = '0;
        @(negedge clk);
        flush = 1'b0;
        idle(8);
        chk("R6", "aborted completions", ncmpl - base, QD);
        for (int i = 0; i < QD; i++) begin
            chk("R6", "abort order tag", log_tag[base + i], 10 + i);
            chk("R6", "abort status", log_ab[base + i], 1);
        end
        for (int i = 1; i < QD; i++)
            chk("R6", "one per cycle", log_cyc[base + i] - log_cyc[base + i - 1], 1);
        chk("R7", "sw_head after flush", int'(sw_head), 0);
        chk("R7", "retired equals posted", int'(retired_cnt), added);
        chk("R7", "free_cnt after flush", int'(free_cnt), RING - 1);
        chk("R7", "q_full after flush", int'(q_full), 0);
        h = 0;

        // R8: post while stopped aborts it behind the earlier request
        base = ncmpl;
        post(2, 2, 5);
        added += 2;
        running = 1'b0;
        post(0, 3, 6);
        idle(6);
        running = 1'b1;
        chk("R8", "aborted count", ncmpl - base, 2);
        chk("R8", "first aborted tag", log_tag[base], 5);
        chk("R8", "second aborted tag", log_tag[base + 1], 6);
        chk("R8", "first status", log_ab[base], 1);
        chk("R8", "second status", log_ab[base + 1], 1);
        chk("R8", "retired equals posted", int'(retired_cnt), added);
        chk("R8", "sw_head", int'(sw_head), 0);

        // R11 and R4: engine resumes after the abort
        base = ncmpl;
        post(3, 3, 7);
        hw_head = 3'd3;
        idle(6);
        chk("R4", "resume completion", ncmpl - base, 1);
        chk("R4", "resume tag", log_tag[base], 7);
        chk("R4", "resume status", log_ab[base], 0);
        for (int i = 1; i < ncmpl; i++)
            if (log_cyc[i] == log_cyc[i - 1])
                chk("R11", "single completion per cycle", log_cyc[i], log_cyc[i - 1] + 1);
        chk("R11", "log bounded", int'(ncmpl <= 256), 1);

        summary();
        $finish;
    end
endmodule